// File: doc/BRIEF.md
# Programmable-Frame Serial Transmitter

This block turns parallel bytes into an asynchronous serial stream. A producer writes bytes into a small transmit queue. A frame sequencer takes each byte off the queue and sends it on a single output line. Each frame has a low start bit, then 5 to 8 data bits sent least significant bit first, then an optional parity bit, then a stop period of 1, 1.5 or 2 bit times. All timing comes from a one-cycle baud strobe that runs at 16 times the bit rate and is made by an external divider. One bit time is 16 strobes.

The frame format (character length, parity mode and long-stop select) is captured when a byte is loaded. Changing the format in the middle of a frame therefore does not disturb that frame. The block reports when the queue is empty or full. It raises a transmitter-idle flag once the queue is empty and the last stop period has ended. A write that arrives while the queue is full is discarded and sets a sticky overflow flag. A break control forces the line low while the sequencer keeps running. The transmit path has no dependence on any receive path, so it can run full duplex beside one.

Top module: `serial_frame_tx`

## Requirements
- R1: The queue holds up to 4 bytes. `fifo_full` is high when 4 bytes are stored and `fifo_empty` is high when none are. The sequencer pops a byte only when the queue is not empty.
- R2: A write while `fifo_full` is high is discarded: the byte is never sent and the stored count does not change. The write sets `wr_overflow`, which then stays high until reset.
- R3: Every frame starts with a low start bit lasting 16 baud strobes. Data bits follow, least significant bit first, each lasting 16 strobes.
- R4: `char_len` encodes 0, 1, 2 and 3 as 5, 6, 7 and 8 data bits. Byte bits above the selected length are not sent and do not affect parity.
- R5: `parity_mode` encoding: 0 gives no parity bit, 1 gives odd parity (the ones across the data bits and the parity bit total an odd number), 2 gives even parity (that total is even), 3 gives no parity bit.
- R6: The line is high during the stop period. The stop period lasts 16 strobes when `stop_long` is 0, 24 strobes when `stop_long` is 1 and `char_len` is 0, and 32 strobes when `stop_long` is 1 and `char_len` is 1 to 3.
- R7: `tx_idle` is high only when the queue is empty and no frame is in progress. It rises on the cycle after the strobe that ends the last stop period.
- R8: While `break_en` is high, `txd` is low from the next cycle on. The frame in progress keeps its timing, so `tx_idle` still rises when that frame would have ended.
- R9: When the queue still holds data at the end of a stop period, the next start bit begins on the following cycle, with no idle gap.
- R10: After reset, `txd` is high, `fifo_empty` and `tx_idle` are high, and `fifo_full` and `wr_overflow` are low. With `break_en` low, `txd` stays high whenever the transmitter is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle strobe at 16 times the bit rate |
| wr_en | input | 1 | Write strobe for the transmit queue |
| wr_data | input | 8 | Byte to queue |
| char_len | input | 2 | Data bits: 0..3 selects 5..8 |
| parity_mode | input | 2 | 0 none, 1 odd, 2 even, 3 none |
| stop_long | input | 1 | 0: one stop bit; 1: 1.5 (5-bit characters) or 2 stop bits |
| break_en | input | 1 | Forces the line low |
| txd | output | 1 | Serial output, idles high |
| fifo_empty | output | 1 | Queue holds no bytes |
| fifo_full | output | 1 | Queue holds 4 bytes |
| tx_idle | output | 1 | Queue empty and no frame in progress |
| wr_overflow | output | 1 | Sticky: a write hit a full queue |

## Verification
The assertions assume that `baud_tick` is a single-cycle strobe. They also assume that format inputs change only between frames when a check depends on them, although the design latches the format at load time. The bench drives one strobe every fourth clock cycle. It changes the format only after `tx_idle` has been seen high and the expected-frame queue has drained. Random bursts never exceed four consecutive writes onto an idle transmitter, so overflow occurs only in the directed six-write case. A line monitor counts strobes from each falling start edge, which keeps its bit sampling aligned with the strobe stream.

// File: rtl/sft_pkg.sv
package sft_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PAR,
    ST_STOP
  } sft_state_e;

  // Clear the byte bits above the selected character length (0..3 -> 5..8 bits).
  function automatic logic [7:0] sft_mask(input logic [7:0] d, input logic [1:0] len);
    return d & (8'hFF >> (2'd3 - len));
  endfunction

  // Parity bit for masked data; odd=1 makes the total number of ones odd.
  function automatic logic sft_parity(input logic [7:0] dm, input logic odd);
    return (^dm) ^ odd;
  endfunction
endpackage

// File: rtl/sft_fifo.sv
module sft_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full,
  output logic         ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          push_ok;

  assign push_ok = push && !full;
  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign dout    = mem[rp];

  // Storage has no reset so it can map onto memory resources.
  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
      ovf <= 1'b0;
    end else begin
      if (push_ok) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
      if (pop)     rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      case ({push_ok, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
      if (push && full) ovf <= 1'b1;
    end
  end

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (rst)
    cnt <= CW'(DEPTH));
  assert_no_underflow_R1: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
  assert_drop_full_R2: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> $stable(cnt));
  assert_ovf_sticky_R2: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
endmodule

// File: rtl/sft_framer.sv
module sft_framer
  import sft_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       fifo_empty,
  input  logic [7:0] fifo_dout,
  input  logic [1:0] cfg_len,
  input  logic [1:0] cfg_par,
  input  logic       cfg_stop_long,
  output logic       pop,
  output logic       line_n,
  output logic       busy
);
  localparam int CW = $clog2(2 * OVS);

  sft_state_e    st, st_n;
  logic [CW-1:0] tc, tc_n, slim_q, slim_n;
  logic [2:0]    bi, bi_n;
  logic [7:0]    sh, sh_n, dm;
  logic          pb, pb_n, pen_q, pen_n, load;
  logic [1:0]    len_q, len_n;

  assign busy = (st != ST_IDLE);
  assign dm   = sft_mask(fifo_dout, cfg_len);

  always_comb begin
    st_n   = st;
    tc_n   = tc;
    bi_n   = bi;
    sh_n   = sh;
    pb_n   = pb;
    pen_n  = pen_q;
    len_n  = len_q;
    slim_n = slim_q;
    load   = 1'b0;
    case (st)
      ST_IDLE: load = !fifo_empty;
      ST_START: if (tick) begin
        if (tc == CW'(OVS - 1)) begin
          st_n = ST_DATA;
          tc_n = '0;
        end else tc_n = tc + 1'b1;
      end
      ST_DATA: if (tick) begin
        if (tc == CW'(OVS - 1)) begin
          tc_n = '0;
          sh_n = sh >> 1;
          if (bi == 3'(len_q) + 3'd4) begin
            st_n = pen_q ? ST_PAR : ST_STOP;
            bi_n = '0;
          end else bi_n = bi + 1'b1;
        end else tc_n = tc + 1'b1;
      end
      ST_PAR: if (tick) begin
        if (tc == CW'(OVS - 1)) begin
          st_n = ST_STOP;
          tc_n = '0;
        end else tc_n = tc + 1'b1;
      end
      ST_STOP: if (tick) begin
        if (tc == slim_q) begin
          tc_n = '0;
          if (!fifo_empty) load = 1'b1;
          else st_n = ST_IDLE;
        end else tc_n = tc + 1'b1;
      end
      default: st_n = ST_IDLE;
    endcase
    if (load) begin
      st_n  = ST_START;
      tc_n  = '0;
      bi_n  = '0;
      sh_n  = dm;
      pb_n  = sft_parity(dm, cfg_par == 2'd1);
      pen_n = (cfg_par == 2'd1) || (cfg_par == 2'd2);
      len_n = cfg_len;
      if (!cfg_stop_long)       slim_n = CW'(OVS - 1);
      else if (cfg_len == 2'd0) slim_n = CW'(OVS + OVS / 2 - 1);
      else                      slim_n = CW'(2 * OVS - 1);
    end
    pop = load;
    case (st_n)
      ST_START: line_n = 1'b0;
      ST_DATA:  line_n = sh_n[0];
      ST_PAR:   line_n = pb_n;
      default:  line_n = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      tc     <= '0;
      bi     <= '0;
      sh     <= '0;
      pb     <= 1'b0;
      pen_q  <= 1'b0;
      len_q  <= '0;
      slim_q <= '0;
    end else begin
      st     <= st_n;
      tc     <= tc_n;
      bi     <= bi_n;
      sh     <= sh_n;
      pb     <= pb_n;
      pen_q  <= pen_n;
      len_q  <= len_n;
      slim_q <= slim_n;
    end
  end

  assert_start_from_fifo_R3: assert property (@(posedge clk) disable iff (rst)
    (st == ST_START && $past(st) != ST_START) |-> $past(!fifo_empty));
  assert_bit_index_R4: assert property (@(posedge clk) disable iff (rst)
    (st == ST_DATA) |-> (bi <= 3'(len_q) + 3'd4));
endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx #(
  parameter int DEPTH = 4,
  parameter int OVS   = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       baud_tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic [1:0] char_len,
  input  logic [1:0] parity_mode,
  input  logic       stop_long,
  input  logic       break_en,
  output logic       txd,
  output logic       fifo_empty,
  output logic       fifo_full,
  output logic       tx_idle,
  output logic       wr_overflow
);
  logic       pop, line_n, busy;
  logic [7:0] fifo_dout;

  sft_fifo #(.W(8), .DEPTH(DEPTH)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .push  (wr_en),
    .din   (wr_data),
    .pop   (pop),
    .dout  (fifo_dout),
    .empty (fifo_empty),
    .full  (fifo_full),
    .ovf   (wr_overflow)
  );

  sft_framer #(.OVS(OVS)) u_framer (
    .clk           (clk),
    .rst           (rst),
    .tick          (baud_tick),
    .fifo_empty    (fifo_empty),
    .fifo_dout     (fifo_dout),
    .cfg_len       (char_len),
    .cfg_par       (parity_mode),
    .cfg_stop_long (stop_long),
    .pop           (pop),
    .line_n        (line_n),
    .busy          (busy)
  );

  assign tx_idle = !busy && fifo_empty;

  always_ff @(posedge clk) begin
    if (rst) txd <= 1'b1;
    else     txd <= break_en ? 1'b0 : line_n;
  end

  assert_break_low_R8: assert property (@(posedge clk) disable iff (rst)
    break_en |=> !txd);
  assert_idle_high_R10: assert property (@(posedge clk) disable iff (rst)
    (tx_idle && !break_en) |=> txd);
endmodule

// File: tb/test_serial_frame_tx.sv
module test_serial_frame_tx;
  logic       clk = 1'b0, rst = 1'b1, baud_tick = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] char_len = '0, parity_mode = '0;
  logic       stop_long = 1'b0, break_en = 1'b0;
  logic       txd, fifo_empty, fifo_full, tx_idle, wr_overflow;

  int n_tests = 0, n_fail = 0;
  logic [7:0] exp_q [$];
  bit mon_en = 1'b0, in_frm = 1'b0, fresh = 1'b0;
  int n, m_len, m_pen, m_tot;
  logic [7:0] m_dat;
  logic m_pb;

  serial_frame_tx i_serial_frame_tx (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_en(wr_en), .wr_data(wr_data),
    .char_len(char_len), .parity_mode(parity_mode), .stop_long(stop_long),
    .break_en(break_en), .txd(txd), .fifo_empty(fifo_empty), .fifo_full(fifo_full),
    .tx_idle(tx_idle), .wr_overflow(wr_overflow)
  );

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] f_mask(input logic [7:0] d, input int len);
    return d & ((8'd1 << len) - 8'd1);
  endfunction

  function automatic logic f_par(input logic [7:0] dm, input int mode);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += dm[i];
    return (mode == 1) ? ((ones % 2) == 0) : ((ones % 2) == 1);
  endfunction

  function automatic int f_stop(input int len, input bit sl);
    if (!sl) return 16;
    return (len == 5) ? 24 : 32;
  endfunction

  // Baud strobe: one cycle high out of every four.
  initial begin
    int div = 0;
    forever begin
      @(posedge clk);
      div = (div == 3) ? 0 : div + 1;
      baud_tick <= (div == 0);
    end
  end

  // Line monitor: counts strobes consumed since the start edge.
  always @(negedge clk) begin
    if (!rst && mon_en) begin
      if (in_frm && fresh) begin
        if (n == 8) chk(txd == 1'b0, "R3 start bit", txd, 0);
        if (n >= 24 && n <= 16 * m_len + 8 && ((n - 8) % 16) == 0)
          chk(txd == m_dat[(n - 8) / 16 - 1], "R3 R4 data bit", txd, m_dat[(n - 8) / 16 - 1]);
        if (m_pen == 1 && n == 16 * (1 + m_len) + 8)
          chk(txd == m_pb, "R5 parity bit", txd, m_pb);
        if (n == 16 * (1 + m_len + m_pen) + 8) chk(txd == 1'b1, "R6 stop level", txd, 1);
        if (n == m_tot - 1) chk(tx_idle == 1'b0, "R6 R7 idle too early", tx_idle, 0);
        if (n == m_tot) begin
          if (exp_q.size() == 0) chk(tx_idle == 1'b1, "R6 R7 idle at stop end", tx_idle, 1);
          else chk(txd == 1'b0, "R9 back-to-back start", txd, 0);
          in_frm = 1'b0;
        end
      end
      fresh = 1'b0;
      if (!in_frm && txd == 1'b0) begin
        if (exp_q.size() == 0) chk(1'b0, "R3 unexpected start", 0, 1);
        else begin
          m_len = 5 + int'(char_len);
          m_pen = (parity_mode == 2'd1 || parity_mode == 2'd2) ? 1 : 0;
          m_dat = f_mask(exp_q.pop_front(), m_len);
          m_pb  = f_par(m_dat, int'(parity_mode));
          m_tot = 16 * (1 + m_len + m_pen) + f_stop(m_len, stop_long);
          in_frm = 1'b1;
          n = 0;
        end
      end
      if (in_frm && baud_tick) begin
        n++;
        fresh = 1'b1;
      end
    end
  end

  task automatic put(input logic [7:0] d, input bit expect_sent);
    @(posedge clk);
    wr_en   <= 1'b1;
    wr_data <= d;
    if (expect_sent) exp_q.push_back(d);
  endtask

  task automatic end_wr();
    @(posedge clk);
    wr_en <= 1'b0;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (!(tx_idle && exp_q.size() == 0 && !in_frm));
    repeat (6) @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] l, input logic [1:0] p, input logic s);
    @(posedge clk);
    char_len    <= l;
    parity_mode <= p;
    stop_long   <= s;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd24680));
    repeat (4) @(posedge clk);
    rst <= 1'b0;
    @(negedge clk);
    chk(txd == 1'b1, "R10 reset txd", txd, 1);
    chk(fifo_empty == 1'b1, "R10 reset empty", fifo_empty, 1);
    chk(fifo_full == 1'b0, "R10 reset full", fifo_full, 0);
    chk(tx_idle == 1'b1, "R10 reset idle", tx_idle, 1);
    chk(wr_overflow == 1'b0, "R10 reset overflow", wr_overflow, 0);
    mon_en = 1'b1;

    // 5 bits, odd parity, upper bits set (R4 R5), then 1.5 and 2 stop periods (R6).
    set_cfg(2'd0, 2'd1, 1'b0); put(8'hE5, 1'b1); end_wr(); wait_idle();
    set_cfg(2'd0, 2'd2, 1'b1); put(8'hB3, 1'b1); end_wr(); wait_idle();
    set_cfg(2'd3, 2'd0, 1'b1); put(8'h96, 1'b1); end_wr(); wait_idle();
    set_cfg(2'd1, 2'd3, 1'b1); put(8'hFF, 1'b1); end_wr(); wait_idle();

    // Six back-to-back writes: five are accepted, the sixth is dropped (R1 R2).
    set_cfg(2'd3, 2'd2, 1'b0);
    put(8'h11, 1'b1);
    put(8'h22, 1'b1);
    @(negedge clk); chk(fifo_empty == 1'b0, "R1 not empty after write", fifo_empty, 0);
    put(8'h33, 1'b1);
    put(8'h44, 1'b1);
    put(8'h55, 1'b1);
    put(8'h66, 1'b0);
    @(negedge clk);
    chk(fifo_full == 1'b1, "R1 full at four", fifo_full, 1);
    chk(wr_overflow == 1'b0, "R2 no overflow yet", wr_overflow, 0);
    end_wr();
    @(negedge clk); chk(wr_overflow == 1'b1, "R2 overflow set", wr_overflow, 1);
    wait_idle();
    chk(wr_overflow == 1'b1, "R2 overflow sticky", wr_overflow, 1);
    chk(fifo_empty == 1'b1, "R1 empty after drain", fifo_empty, 1);
    chk(fifo_full == 1'b0, "R1 not full after drain", fifo_full, 0);

    // Random formats and bursts of 1..4 bytes (R3 R4 R5 R6 R9).
    for (int it = 0; it < 20; it++) begin
      int cnt;
      set_cfg(2'($urandom_range(3)), 2'($urandom_range(3)), 1'($urandom_range(1)));
      cnt = $urandom_range(1, 4);
      for (int k = 0; k < cnt; k++) put(8'($urandom), 1'b1);
      end_wr();
      wait_idle();
    end

    // Break: line held low while the frame still finishes on time (R8).
    mon_en = 1'b0;
    set_cfg(2'd3, 2'd0, 1'b0);
    put(8'hA5, 1'b0); end_wr();
    do @(negedge clk); while (tx_idle);
    @(posedge clk); break_en <= 1'b1;
    repeat (2) @(negedge clk);
    chk(txd == 1'b0, "R8 break forces low", txd, 0);
    begin
      int cyc = 0;
      bit hi_seen = 1'b0;
      while (!tx_idle && cyc < 1000) begin
        if (txd) hi_seen = 1'b1;
        @(negedge clk);
        cyc++;
      end
      chk(!hi_seen, "R8 line stays low in break", hi_seen, 0);
      chk(tx_idle == 1'b1, "R8 frame completes under break", tx_idle, 1);
    end
    chk(txd == 1'b0, "R8 low while break held", txd, 0);
    @(posedge clk); break_en <= 1'b0;
    repeat (2) @(negedge clk);
    chk(txd == 1'b1, "R10 idle line high after break", txd, 1);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule